// File: doc/BRIEF.md
# Mode-Switched Cartridge Bank Controller

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge's ROM and RAM. The CPU configures it by writing into the ROM address window, which the ROM itself ignores. Those writes set a RAM enable flag, the low five bits of the switchable ROM bank, a two-bit shared field, and a mode bit.

The two-bit field serves either the ROM bank (bits 6:5) or the RAM bank, depending on the mode. When the mode changes, the bits move from one owner to the other.

From the CPU address, the block computes two physical addresses:
- a ROM address made of a 7-bit bank and a 14-bit offset;
- a RAM address made of a 2-bit bank and a 13-bit offset.

It also drives read strobes toward both arrays, a RAM write strobe, and a zero indication for reads whose bank lies past the memory that is present. The counts of present ROM and RAM banks are parameters. A RAM count of zero means the cartridge has no RAM.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM enable (`ram_en`) is 0 and the controller is in ROM-banking mode.
- R2: A write to 0x0000–0x1FFF sets `ram_en` to 1 on the next clock edge when the data byte is 0x0A. Any other byte sets it to 0.
- R3: A write to 0x2000–0x3FFF replaces ROM bank bits 4:0 with data[4:0] and keeps bits 6:5. If the resulting bits 4:0 are zero, bit 0 becomes 1, so 0x00, 0x20, 0x40 and 0x60 turn into 0x01, 0x21, 0x41 and 0x61.
- R4: A write to 0x4000–0x5FFF loads data[1:0] into the RAM bank in RAM-banking mode. In ROM-banking mode it loads data[1:0] into ROM bank bits 6:5.
- R5: A write to 0x6000–0x7FFF selects the mode from data[0], where 1 means RAM banking. Entering RAM banking moves ROM bank bits 6:5 into the RAM bank and clears them. Leaving it moves the RAM bank into ROM bank bits 6:5 and clears the RAM bank.
- R6: A mode write whose data[0] equals the current mode leaves both banks unchanged.
- R7: `rom_addr` is {bank, cpu_addr[13:0]}, where bank is 0 when cpu_addr[14] is 0 and the current ROM bank when it is 1.
- R8: `ram_addr` is {RAM bank, cpu_addr[12:0]}, so each RAM bank spans 8 KiB.
- R9: A read of 0x4000–0x7FFF with the ROM bank at or above ROM_BANKS, or a read of 0xA000–0xBFFF with the RAM bank at or above RAM_BANKS, raises `rd_zero` and raises neither `rom_rd` nor `ram_rd`. Reads of 0x0000–0x3FFF are never out of range.
- R10: `ram_we` rises only for a write to 0xA000–0xBFFF while RAM is present and the RAM bank is in range. With RAM_BANKS = 0, RAM reads raise `rd_zero` and RAM writes are dropped.
- R11: Writes to 0x8000–0x9FFF and 0xC000–0xFFFF change no bank, mode or enable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| rom_addr | output | 21 | Physical ROM address {bank, offset} |
| ram_addr | output | 15 | Physical RAM address {bank, offset} |
| rom_rd | output | 1 | In-range ROM read |
| ram_rd | output | 1 | In-range RAM read |
| ram_we | output | 1 | RAM write strobe |
| ram_en | output | 1 | RAM enable flag |
| rd_zero | output | 1 | Read out of range; data must read as zero |

## Verification
The hardest state to reach is one where the shared bits have moved between owners and then come back. Reaching it takes a ROM write that sets bits 6:5, a mode entry, a RAM-bank rewrite while in RAM mode, and finally a mode exit. Only then does a composite bank such as 0x67 appear on the ROM address.

The stimulus table walks exactly that chain, with repeated same-mode writes placed in between. It then pushes the ROM bank to 0x61, past a 96-bank limit, and the RAM bank past a 2-bank limit, to provoke the zero indication. A second instance built with no RAM covers the dropped-write path.

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl #(
  parameter int ROM_BANKS = 128,
  parameter int RAM_BANKS = 4,
  parameter int LO_BITS   = 5,
  parameter int HI_BITS   = 2,
  parameter int ROM_OFS   = 14,
  parameter int RAM_OFS   = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  input  logic                          cpu_wr,
  input  logic                          cpu_rd,
  output logic [LO_BITS+HI_BITS+ROM_OFS-1:0] rom_addr,
  output logic [HI_BITS+RAM_OFS-1:0]    ram_addr,
  output logic                          rom_rd,
  output logic                          ram_rd,
  output logic                          ram_we,
  output logic                          ram_en,
  output logic                          rd_zero
);
  localparam int  BW      = LO_BITS + HI_BITS;
  localparam bit  HAS_RAM = RAM_BANKS > 0;

  logic [BW-1:0]      rom_bank;
  logic [HI_BITS-1:0] ram_bank;
  logic               ram_mode;

  logic [2:0] region;
  logic       in_ram_win, rom_oob, ram_oob;
  logic [BW-1:0] eff_bank;
  logic [LO_BITS-1:0] lo_new;

  assign region     = cpu_addr[15:13];
  assign in_ram_win = (region == 3'b101);
  assign lo_new     = (cpu_wdata[LO_BITS-1:0] == '0) ? LO_BITS'(1) : cpu_wdata[LO_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_bank <= BW'(1);
      ram_bank <= '0;
      ram_mode <= 1'b0;
      ram_en   <= 1'b0;
    end else if (cpu_wr) begin
      case (region)
        3'd0: ram_en <= (cpu_wdata == 8'h0A);
        3'd1: rom_bank[LO_BITS-1:0] <= lo_new;
        3'd2: begin
          if (ram_mode) ram_bank <= cpu_wdata[HI_BITS-1:0];
          else          rom_bank[BW-1:LO_BITS] <= cpu_wdata[HI_BITS-1:0];
        end
        3'd3: begin
          if (cpu_wdata[0] != ram_mode) begin
            ram_mode <= cpu_wdata[0];
            if (cpu_wdata[0]) begin
              ram_bank <= rom_bank[BW-1:LO_BITS];
              rom_bank[BW-1:LO_BITS] <= '0;
            end else begin
              rom_bank[BW-1:LO_BITS] <= ram_bank;
              ram_bank <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign eff_bank = cpu_addr[ROM_OFS] ? rom_bank : '0;
  assign rom_addr = {eff_bank, cpu_addr[ROM_OFS-1:0]};
  assign ram_addr = {ram_bank, cpu_addr[RAM_OFS-1:0]};

  assign rom_oob = cpu_addr[ROM_OFS] && (32'(rom_bank) >= ROM_BANKS);
  assign ram_oob = !HAS_RAM || (32'(ram_bank) >= RAM_BANKS);

  assign rd_zero = cpu_rd && ((!cpu_addr[15] && rom_oob) || (in_ram_win && ram_oob));
  assign rom_rd  = cpu_rd && !cpu_addr[15] && !rom_oob;
  assign ram_rd  = cpu_rd && in_ram_win && !ram_oob;
  assign ram_we  = cpu_wr && in_ram_win && !ram_oob;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
`timescale 1ns/1ps
module cart_bank_ctrl_chk #(
  parameter int BW      = 7,
  parameter int ROM_OFS = 14,
  parameter int LO_BITS = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [15:0]            cpu_addr,
  input logic [7:0]             cpu_wdata,
  input logic                   cpu_wr,
  input logic [BW+ROM_OFS-1:0]  rom_addr,
  input logic                   rom_rd,
  input logic                   ram_rd,
  input logic                   ram_we,
  input logic                   ram_en,
  input logic                   rd_zero
);
  assert_enable_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000) |=> (ram_en == ($past(cpu_wdata) == 8'h0A)));

  assert_low_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_OFS+LO_BITS-1:ROM_OFS] != '0));

  assert_fixed_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr[BW+ROM_OFS-1:ROM_OFS] == '0));

  assert_read_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd, ram_rd, rd_zero}));

  assert_ram_write_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b101));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.BW(BW), .ROM_OFS(ROM_OFS), .LO_BITS(LO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
  .rom_addr(rom_addr), .rom_rd(rom_rd), .ram_rd(ram_rd), .ram_we(ram_we),
  .ram_en(ram_en), .rd_zero(rd_zero)
);

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [20:0] rom_addr, n_rom_addr;
  logic [14:0] ram_addr, n_ram_addr;
  logic rom_rd, ram_rd, ram_we, ram_en, rd_zero;
  logic n_rom_rd, n_ram_rd, n_ram_we, n_ram_en, n_rd_zero;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(96), .RAM_BANKS(2)) i_cart_bank_ctrl (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_wr, .cpu_rd,
    .rom_addr, .ram_addr, .rom_rd, .ram_rd, .ram_we, .ram_en, .rd_zero);

  cart_bank_ctrl #(.ROM_BANKS(96), .RAM_BANKS(0)) i_cart_bank_ctrl_noram (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_wr, .cpu_rd,
    .rom_addr(n_rom_addr), .ram_addr(n_ram_addr), .rom_rd(n_rom_rd), .ram_rd(n_ram_rd),
    .ram_we(n_ram_we), .ram_en(n_ram_en), .rd_zero(n_rd_zero));

  // {write address, write data, expected ROM bank, expected RAM bank}
  localparam logic [32:0] VEC [13] = '{
    {16'h2000, 8'h00, 7'h01, 2'd0},  // R3 zero -> 1
    {16'h2000, 8'h1F, 7'h1F, 2'd0},  // R3
    {16'h4000, 8'h02, 7'h5F, 2'd0},  // R4 ROM mode
    {16'h2000, 8'h20, 7'h41, 2'd0},  // R3 0x40 -> 0x41
    {16'h6000, 8'h01, 7'h01, 2'd2},  // R5 enter RAM mode
    {16'h6000, 8'h01, 7'h01, 2'd2},  // R6 same mode
    {16'h4000, 8'h03, 7'h01, 2'd3},  // R4 RAM mode
    {16'h2000, 8'h07, 7'h07, 2'd3},  // R3
    {16'h6000, 8'h00, 7'h67, 2'd0},  // R5 leave RAM mode
    {16'h6000, 8'hFE, 7'h67, 2'd0},  // R6 same mode
    {16'h4000, 8'hFD, 7'h27, 2'd0},  // R4 ROM mode
    {16'h8000, 8'h55, 7'h27, 2'd0},  // R11 ignored
    {16'h3FFF, 8'h60, 7'h21, 2'd0}   // R3 0x20 -> 0x21
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic rd);
    cpu_addr = a; cpu_rd = rd;
    #1;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe(16'h4000, 1'b0); chk("R1 rom bank", 32'(rom_addr[20:14]), 32'h01);
    probe(16'hA000, 1'b0); chk("R1 ram bank", 32'(ram_addr[14:13]), 0);
    chk("R1 ram_en", 32'(ram_en), 0);
    probe(16'h1234, 1'b0); chk("R7 fixed bank", 32'(rom_addr), 32'h1234);

    foreach (VEC[i]) begin
      wr(VEC[i][32:17], VEC[i][16:9]);
      probe(16'h4000, 1'b0); chk("R3/R4/R5/R6/R11 rom bank", 32'(rom_addr[20:14]), 32'(VEC[i][8:2]));
      probe(16'hA000, 1'b0); chk("R4/R5/R6/R11 ram bank", 32'(ram_addr[14:13]), 32'(VEC[i][1:0]));
    end

    wr(16'h0000, 8'h0A); chk("R2 enable", 32'(ram_en), 1);
    wr(16'hC000, 8'h00); chk("R11 high write", 32'(ram_en), 1);
    wr(16'h1FFF, 8'h0B); chk("R2 disable", 32'(ram_en), 0);
    wr(16'h0000, 8'h0A); wr(16'h0100, 8'h1A); chk("R2 disable other", 32'(ram_en), 0);

    probe(16'h7ABC, 1'b1); chk("R7 rom addr", 32'(rom_addr), {11'd0, 7'h21, 14'h3ABC});
    chk("R9 in range", 32'({rom_rd, rd_zero}), 32'b10);
    wr(16'h4000, 8'h03);
    probe(16'h4000, 1'b1); chk("R9 rom oob", 32'({rom_rd, rd_zero}), 32'b01);
    probe(16'h0100, 1'b1); chk("R9 bank0 ok", 32'({rom_rd, rd_zero}), 32'b10);

    wr(16'h6000, 8'h01);
    probe(16'hA000, 1'b1); chk("R9 ram oob", 32'({ram_rd, rd_zero}), 32'b01);
    cpu_rd = 1'b0;
    @(negedge clk); cpu_addr = 16'hA000; cpu_wr = 1'b1; #1;
    chk("R10 oob write dropped", 32'(ram_we), 0);
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h4000, 8'h01);
    probe(16'hB5A5, 1'b1); chk("R8 ram addr", 32'(ram_addr), {17'd0, 2'd1, 13'h15A5});
    chk("R9 ram ok", 32'({ram_rd, rd_zero}), 32'b10);
    chk("R10 no-ram read", 32'({n_ram_rd, n_rd_zero}), 32'b01);
    cpu_rd = 1'b0;
    @(negedge clk); cpu_addr = 16'hB000; cpu_wr = 1'b1; #1;
    chk("R10 ram write", 32'(ram_we), 1);
    chk("R10 no-ram write dropped", 32'(n_ram_we), 0);
    @(negedge clk); cpu_wr = 1'b0; cpu_addr = 16'h9000; #1;
    chk("R10 idle", 32'(ram_we), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule